// File: doc/BRIEF.md
# Indexed-Color Pixel Scanout Engine

This block streams a frame out of an 8-bit-per-pixel video memory. Each stored byte is an index into an internal 256-entry color table. The table holds one red, one green and one blue byte per entry. Out of the block comes a stream of 24-bit pixels under a valid/ready handshake, tagged with start-of-frame and end-of-line markers. A frame begins on a one-cycle `start` pulse. The width and height are captured at that moment. Memory is walked row by row, with x moving fastest and one byte per pixel, beginning at address 0.

A force-blank control picks between graphic and blank output. The block keeps the mode that was used for the last accepted start. When a start finds a different mode, the frame it launches is tagged as a full refresh on `px_full`. Reset and the `invalidate` pulse have the same effect. In blank mode every pixel is black, and a blank frame is sent only when a full refresh is due. A frame with a zero width or a zero height sends nothing, but the start still records the mode.

The video memory is read outside the block with a combinational port (`vm_addr` to `vm_byte`). The color table is loaded through a simple write port.

Top module: `idx_scanout`

## Requirements
- R1: After reset `px_valid` and `busy` are 0. The first frame that follows reset is tagged full (`px_full`=1).
- R2: Pixel k of a W×H frame is read from address k, counting from 0 with x fastest. `px_sof` is 1 only on pixel 0. `px_eol` is 1 on each pixel whose x equals W-1. Exactly W·H pixels are sent.
- R3: In graphic mode each pixel's `px_data` is the color entry selected by the fetched byte, packed as {red[23:16], green[15:8], blue[7:0]}. It appears one cycle after the address is presented.
- R4: A start with width 0 or height 0 produces no pixels, and it still records the requested mode.
- R5: In blank mode (`blank_req`=1 at start) every pixel of the frame is 24'h000000.
- R6: A start whose mode differs from the previous accepted start tags its frame full. The same mode again gives `px_full`=0.
- R7: A blank-mode start that is not due for a full refresh produces no pixels.
- R8: An `invalidate` pulse, alone or in the same cycle as a start, makes the next accepted start tagged full.
- R9: While `px_valid`=1 and `px_ready`=0, `px_data`, `px_sof`, `px_eol` and `vm_addr` hold their values and no pixel is lost.
- R10: A change to `cfg_width` or `cfg_height` during a frame does not affect that frame.
- R11: A `start` pulse while `busy`=1 is ignored and launches no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle frame request |
| blank_req | input | 1 | Force-blank control, sampled at start |
| invalidate | input | 1 | Force the next frame to be a full refresh |
| cfg_width | input | XW | Frame width in pixels, sampled at start |
| cfg_height | input | YW | Frame height in lines, sampled at start |
| pal_we | input | 1 | Color table write enable |
| pal_waddr | input | 8 | Color table entry to write |
| pal_wdata | input | 24 | Color {red, green, blue} to write |
| vm_addr | output | AW | Video memory byte address |
| vm_byte | input | 8 | Video memory byte at `vm_addr` (combinational) |
| busy | output | 1 | Frame walk in progress |
| px_valid | output | 1 | Output pixel valid |
| px_ready | input | 1 | Downstream accepts the pixel |
| px_data | output | 24 | Output pixel {red, green, blue} |
| px_sof | output | 1 | First pixel of the frame |
| px_eol | output | 1 | Last pixel of a line |
| px_full | output | 1 | Pixel belongs to a full-refresh frame |

## Verification
A wrong remembered mode is not visible until the next start. It then shows up as a wrong `px_full` on that frame's first pixel, or as a blank frame that appears or goes missing with no other sign. A raster counter that is off by one shows up within a single line. Pixel data starts coming from the wrong address, and `px_eol` falls on the wrong pixel. A stage that drops the stall shows at once: a repeated or skipped color appears on the first pixel after `px_ready` rises again.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IDX_W       = 8;
    localparam int PAL_ENTRIES = 1 << IDX_W;
    localparam int CH_W        = 8;

    typedef enum logic [1:0] {
        MODE_GRAPH = 2'd0,
        MODE_BLANK = 2'd1,
        MODE_NONE  = 2'd2
    } scan_mode_e;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic sof;
        logic eol;
        logic full;
        logic blank;
    } mark_t;

    function automatic rgb_t black_px();
        return '0;
    endfunction

    function automatic scan_mode_e mode_of(input logic blank);
        return blank ? MODE_BLANK : MODE_GRAPH;
    endfunction

endpackage

// File: rtl/scan_mode_track.sv
module scan_mode_track
    import scan_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          busy,
    input  logic          blank_req,
    input  logic          invalidate,
    input  logic [XW-1:0] w,
    input  logic [YW-1:0] h,
    output logic          go,
    output logic          go_full,
    output logic          go_blank
);

    scan_mode_e prev_q;
    scan_mode_e eff_prev;
    scan_mode_e cur;
    logic       accept;
    logic       nonzero;

    always_comb begin
        eff_prev = invalidate ? MODE_NONE : prev_q;
        cur      = mode_of(blank_req);
        accept   = start && !busy;
        nonzero  = (w != '0) && (h != '0);
        go_full  = (cur != eff_prev);
        go_blank = (cur == MODE_BLANK);
        go       = accept && nonzero && (!go_blank || go_full);
    end

    always_ff @(posedge clk) begin
        if (rst)             prev_q <= MODE_NONE;
        else if (accept)     prev_q <= cur;
        else if (invalidate) prev_q <= MODE_NONE;
    end

    // R7: a blank frame is only launched when a full refresh is due
    p_blank_full_r7: assert property (@(posedge clk) disable iff (rst)
        go && go_blank |-> go_full);

    // R11: no frame is launched while one is running
    p_no_go_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !go);

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 10,
    parameter int AW = XW + YW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_full,
    input  logic          go_blank,
    input  logic [XW-1:0] w,
    input  logic [YW-1:0] h,
    input  logic          adv,
    output logic          active,
    output logic [AW-1:0] addr,
    output mark_t         mk
);

    logic [XW-1:0] x_q, w_q;
    logic [YW-1:0] y_q, h_q;
    logic          full_q, blank_q;
    logic          at_eol, at_last_row;

    always_comb begin
        at_eol      = (x_q == w_q - XW'(1));
        at_last_row = (y_q == h_q - YW'(1));
        mk.sof      = (x_q == '0) && (y_q == '0);
        mk.eol      = at_eol;
        mk.full     = full_q;
        mk.blank    = blank_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            x_q     <= '0;
            y_q     <= '0;
            addr    <= '0;
            w_q     <= '0;
            h_q     <= '0;
            full_q  <= 1'b0;
            blank_q <= 1'b0;
        end else if (!active) begin
            if (go) begin
                active  <= 1'b1;
                x_q     <= '0;
                y_q     <= '0;
                addr    <= '0;
                w_q     <= w;
                h_q     <= h;
                full_q  <= go_full;
                blank_q <= go_blank;
            end
        end else if (adv) begin
            addr <= addr + AW'(1);
            if (at_eol) begin
                x_q <= '0;
                if (at_last_row) active <= 1'b0;
                else             y_q    <= y_q + YW'(1);
            end else begin
                x_q <= x_q + XW'(1);
            end
        end
    end

    // R9: the fetch address holds while the output is stalled
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        active && !adv |=> active && $stable(addr));

    // R2: consecutive pixels come from consecutive addresses
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        active && adv && !(at_eol && at_last_row) |=> active && (addr == $past(addr) + AW'(1)));

    // R2: the first pixel of a frame is fetched from address 0
    p_sof_addr_r2: assert property (@(posedge clk) disable iff (rst)
        active && mk.sof |-> addr == '0);

    // R4: a running frame never has a zero dimension
    p_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        active |-> (w_q != '0) && (h_q != '0));

endmodule

// File: rtl/scan_palette.sv
module scan_palette
    import scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pal_we,
    input  logic [IDX_W-1:0] pal_waddr,
    input  rgb_t             pal_wdata,
    input  logic [IDX_W-1:0] idx,
    input  logic             issue,
    input  mark_t            mk_in,
    input  logic             adv,
    output logic             valid,
    output rgb_t             data,
    output mark_t            mk_out
);

    rgb_t  table_q [PAL_ENTRIES];
    rgb_t  rd_q;

    always_ff @(posedge clk) begin
        if (pal_we) table_q[pal_waddr] <= pal_wdata;
    end

    always_ff @(posedge clk) begin
        if (adv && issue) rd_q <= table_q[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            mk_out <= '0;
        end else if (adv) begin
            valid  <= issue;
            mk_out <= mk_in;
        end
    end

    always_comb data = mk_out.blank ? black_px() : rd_q;

    // R9: a stalled pixel and its markers hold until accepted
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        valid && !adv |=> valid && $stable(data) && $stable(mk_out));

endmodule

// File: rtl/idx_scanout.sv
module idx_scanout
    import scan_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 10,
    parameter int AW = XW + YW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                blank_req,
    input  logic                invalidate,
    input  logic [XW-1:0]       cfg_width,
    input  logic [YW-1:0]       cfg_height,
    input  logic                pal_we,
    input  logic [IDX_W-1:0]    pal_waddr,
    input  logic [3*CH_W-1:0]   pal_wdata,
    output logic [AW-1:0]       vm_addr,
    input  logic [IDX_W-1:0]    vm_byte,
    output logic                busy,
    output logic                px_valid,
    input  logic                px_ready,
    output logic [3*CH_W-1:0]   px_data,
    output logic                px_sof,
    output logic                px_eol,
    output logic                px_full
);

    logic  go, go_full, go_blank, adv;
    mark_t mk_issue, mk_out;
    rgb_t  pix;

    always_comb adv = !px_valid || px_ready;

    scan_mode_track #(.XW(XW), .YW(YW)) u_mode (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .blank_req(blank_req), .invalidate(invalidate),
        .w(cfg_width), .h(cfg_height),
        .go(go), .go_full(go_full), .go_blank(go_blank)
    );

    scan_addr_gen #(.XW(XW), .YW(YW), .AW(AW)) u_addr (
        .clk(clk), .rst(rst), .go(go), .go_full(go_full), .go_blank(go_blank),
        .w(cfg_width), .h(cfg_height), .adv(adv),
        .active(busy), .addr(vm_addr), .mk(mk_issue)
    );

    scan_palette u_pal (
        .clk(clk), .rst(rst), .pal_we(pal_we), .pal_waddr(pal_waddr),
        .pal_wdata(rgb_t'(pal_wdata)), .idx(vm_byte), .issue(busy),
        .mk_in(mk_issue), .adv(adv),
        .valid(px_valid), .data(pix), .mk_out(mk_out)
    );

    always_comb begin
        px_data = pix;
        px_sof  = mk_out.sof;
        px_eol  = mk_out.eol;
        px_full = mk_out.full;
    end

    // R1: nothing is presented in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !px_valid && !busy);

endmodule

// File: tb/test_idx_scanout.sv
module test_idx_scanout;

    localparam int XW = 10;
    localparam int YW = 10;
    localparam int AW = XW + YW;

    logic          clk = 1'b0;
    logic          rst, start, blank_req, invalidate, pal_we, px_ready;
    logic [XW-1:0] cfg_width;
    logic [YW-1:0] cfg_height;
    logic [7:0]    pal_waddr;
    logic [23:0]   pal_wdata;
    logic [AW-1:0] vm_addr;
    logic [7:0]    vm_byte;
    logic          busy, px_valid, px_sof, px_eol, px_full;
    logic [23:0]   px_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_at(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic logic [23:0] color_of(input logic [7:0] i);
        return {i ^ 8'h5A, i + 8'd17, ~i};
    endfunction

    assign vm_byte = mem_at(int'(vm_addr));

    idx_scanout #(.XW(XW), .YW(YW)) i_idx_scanout (
        .clk(clk), .rst(rst), .start(start), .blank_req(blank_req),
        .invalidate(invalidate), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .vm_addr(vm_addr), .vm_byte(vm_byte), .busy(busy),
        .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
        .px_sof(px_sof), .px_eol(px_eol), .px_full(px_full)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs one frame request and checks every pixel sent afterwards.
    task automatic run_frame(input int w, input int h, input bit bl, input bit inv,
                             input bit exp_full, input int exp_n, input int stall,
                             input bit poke, input string req);
        int n = 0;
        int bad = 0;
        @(negedge clk);
        cfg_width  = XW'(w);
        cfg_height = YW'(h);
        blank_req  = bl;
        invalidate = inv;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        invalidate = 1'b0;
        for (int c = 0; c < exp_n * 4 + 40; c++) begin
            if (poke && c == 2) begin
                cfg_width  = XW'(w + 3);
                cfg_height = YW'(h + 2);
            end
            start    = poke && (c == 3);
            px_ready = (stall == 0) || (c % stall != 0);
            if (px_valid && px_ready) begin
                logic [23:0] ed;
                ed = bl ? 24'h0 : color_of(mem_at(n));
                if (w > 0 && (px_data !== ed || px_sof !== (n == 0) ||
                    px_eol !== ((n % w) == w - 1) || px_full !== exp_full)) begin
                    if (bad == 0)
                        $display("FAIL %s: pixel %0d data %0h sof %0b eol %0b full %0b, expected %0h full %0b",
                                 req, n, px_data, px_sof, px_eol, px_full, ed, exp_full);
                    bad++;
                end
                n++;
            end
            @(negedge clk);
        end
        start    = 1'b0;
        px_ready = 1'b1;
        check(n == exp_n, req, n, exp_n);
        if (exp_n > 0) begin
            checks++;
            if (bad != 0) errors++;
        end
    endtask

    task automatic load_palette();
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pal_we    = 1'b1;
            pal_waddr = 8'(i);
            pal_wdata = color_of(8'(i));
        end
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic test_reset_r1();
        check(px_valid == 1'b0, "R1 valid after reset", int'(px_valid), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        run_frame(4, 3, 1'b0, 1'b0, 1'b1, 12, 0, 1'b0, "R1 R2 R3 first frame full");
    endtask

    task automatic test_graphic_r3();
        run_frame(5, 2, 1'b0, 1'b0, 1'b0, 10, 0, 1'b0, "R6 R3 same mode not full");
        run_frame(7, 4, 1'b0, 1'b0, 1'b0, 28, 3, 1'b0, "R9 R2 stalled frame");
        run_frame(1, 5, 1'b0, 1'b0, 1'b0, 5, 2, 1'b0, "R2 one column");
    endtask

    task automatic test_zero_r4();
        run_frame(0, 4, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "R4 zero width");
        run_frame(3, 0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "R4 zero height");
        run_frame(0, 3, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R4 zero blank records mode");
        run_frame(3, 2, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R4 R7 blank after zero");
        run_frame(3, 2, 1'b0, 1'b0, 1'b1, 6, 0, 1'b0, "R4 R6 graphic after blank");
    endtask

    task automatic test_blank_r5();
        run_frame(6, 3, 1'b1, 1'b0, 1'b1, 18, 4, 1'b0, "R5 R6 blank black frame");
        run_frame(6, 3, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R7 repeated blank silent");
    endtask

    task automatic test_invalidate_r8();
        run_frame(4, 2, 1'b0, 1'b0, 1'b1, 8, 0, 1'b0, "R6 back to graphic");
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        run_frame(4, 2, 1'b0, 1'b0, 1'b1, 8, 0, 1'b0, "R8 invalidate pulse");
        run_frame(3, 3, 1'b1, 1'b1, 1'b1, 9, 0, 1'b0, "R8 invalidate with start");
    endtask

    task automatic test_latch_r10();
        run_frame(4, 3, 1'b0, 1'b0, 1'b1, 12, 0, 1'b1, "R10 R11 mid-frame changes");
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; blank_req = 1'b0; invalidate = 1'b0;
        pal_we = 1'b0; pal_waddr = '0; pal_wdata = '0; px_ready = 1'b1;
        cfg_width = '0; cfg_height = '0;
        do_reset();
        load_palette();
        test_reset_r1();
        test_graphic_r3();
        test_zero_r4();
        test_blank_r5();
        test_invalidate_r8();
        test_latch_r10();
        do_reset();
        check(px_valid == 1'b0 && busy == 1'b0, "R1 idle after second reset", int'(busy), 0);
        run_frame(2, 2, 1'b0, 1'b0, 1'b1, 4, 0, 1'b0, "R1 full after second reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule